// File: doc/BRIEF.md
# Prescaled Auto-Reload Down-Counter Timer Channel

A single timer channel behind a small word-addressed register interface. A free-running prescaler divides the clock into count ticks. While the enable bit of the control register is set, each tick decrements a 16-bit counter. A tick that finds the counter at zero is an underflow. The counter then reloads from the count-buffer register, the same value is copied into a read-only observation register, and a one-cycle interrupt request goes to the interrupt controller.

Two configuration words are stored and read back, and nothing else uses them. The channel has no compare stage and no output pin. Software sets the period by writing the count buffer, starts the channel through the control register, and reads the observation register to see the value the counter last reloaded.

Register map (word index on `addr_i`): 0 = config word A, 1 = config word B, 2 = control, 3 = count buffer, 4 = observation (read-only). Indices 5 to 7 are unmapped.

Top module: `prescaled_timer`

## Requirements
- R1: After reset every register index (0 to 7) reads 0, `irq_o` is low and the counter is 0.
- R2: The prescaler starts at PRESC_DIV and counts down one per clock. In the cycle where it stands at 0 it issues a tick and goes back to PRESC_DIV, so ticks come every PRESC_DIV+1 clocks. Each tick decrements the counter by one while the channel is enabled.
- R3: The channel is enabled by bit 20 of the control register (index 2). While that bit is 0 the counter holds its value and no interrupt is raised.
- R4: A tick that finds the enabled counter at 0 is an underflow. On that clock edge the counter and the observation register (index 4) both load the count buffer.
- R5: `irq_o` is high for exactly the clock cycle after each underflow edge and is low otherwise.
- R6: While the channel is enabled without interruption and the count buffer holds N, underflows repeat every (N+1)*(PRESC_DIV+1) clocks.
- R7: Config words A and B (indices 0, 1) and the control register (index 2) read back the full 32-bit value last written.
- R8: The count buffer (index 3) stores the low 16 bits of a write and reads back zero-extended.
- R9: Writes to the observation register and to indices 5 to 7 have no effect. Indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one word per cycle |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, one-cycle pulse per underflow |

## Verification
The bench compares the outputs against a behavioural model on every clock, so any error in the count or in the pulse timing shows up. The bench checks these corner cases:
- Enabling the channel with the counter at its reset value of 0. A design that treats this differently skips or delays the first underflow.
- Reloading below zero rather than at zero. A design that reloads at zero has a period one tick short.
- Dropping the enable partway through a count. A design that leaks ticks comes back early.
- Changing the count buffer between underflows. The observation register must follow only at the next underflow.
- Writes to the read-only and unmapped indices. A design that decodes them loosely corrupts the observation register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_CFG_A  = 3'd0,
    REG_CFG_B  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_RELOAD = 3'd3,
    REG_OBS    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV < 2) ? 1 : $clog2(DIV + 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= PW'(DIV);
    else if (tick_o)  pre_q <= PW'(DIV);
    else              pre_q <= pre_q - 1'b1;
  end

  assert_pre_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pre_q) <= int'(DIV));

  generate
    if (DIV > 0) begin : g_spacing
      assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] obs_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, obs_q;
  logic             irq_q;
  logic             step, under;

  assign step  = tick_i && en_i;
  assign under = step && (cnt_q == '0);   // borrow out of the decrement

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      obs_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= under;
      if (under) begin
        cnt_q <= reload_i;
        obs_q <= reload_i;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign obs_o = obs_q;
  assign irq_o = irq_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && cnt_q == '0) |=> (cnt_q == $past(reload_i) && obs_q == $past(reload_i)));
  assert_irq_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && en_i && cnt_q == '0) |=> !irq_q);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned EN_BIT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CNT_W-1:0]  obs_i,
  output logic [DW-1:0]     rdata_o,
  output logic              en_o,
  output logic [CNT_W-1:0]  reload_o
);
  logic [DW-1:0]    cfg_a_q, cfg_b_q, ctrl_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q  <= '0;
      cfg_b_q  <= '0;
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        REG_CFG_A:  cfg_a_q  <= wdata_i;
        REG_CFG_B:  cfg_b_q  <= wdata_i;
        REG_CTRL:   ctrl_q   <= wdata_i;
        REG_RELOAD: reload_q <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_CFG_A:  rdata_o = cfg_a_q;
      REG_CFG_B:  rdata_o = cfg_b_q;
      REG_CTRL:   rdata_o = ctrl_q;
      REG_RELOAD: rdata_o = DW'(reload_q);
      REG_OBS:    rdata_o = DW'(obs_i);
      default:    rdata_o = '0;
    endcase
  end

  assign en_o     = ctrl_q[EN_BIT];
  assign reload_o = reload_q;

  assert_ctrl_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CTRL) |=> (ctrl_q == $past(wdata_i)));
  assert_reload_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_RELOAD) |=> (reload_q == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned EN_BIT    = 20,
  parameter int unsigned PRESC_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic             tick, en;
  logic [CNT_W-1:0] reload, obs;

  tmr_prescaler #(.DIV(PRESC_DIV)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  tmr_regs #(.DW(DW), .CNT_W(CNT_W), .EN_BIT(EN_BIT)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .obs_i   (obs),
    .rdata_o (rdata_o),
    .en_o    (en),
    .reload_o(reload)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .en_i    (en),
    .reload_i(reload),
    .obs_o   (obs),
    .irq_o   (irq_o)
  );

  // observation register only moves on underflow, never on a write
  assert_obs_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_OBS) |=> (irq_o || $stable(obs)));
endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  localparam int DIV = 1;
  localparam int EN  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  prescaled_timer #(.PRESC_DIV(DIV)) i_prescaled_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          m_pre = DIV, m_cnt = 0, m_obs = 0, m_rel = 0;
  bit          m_irq = 0;
  logic [31:0] m_a = '0, m_b = '0, m_ctrl = '0;

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_a;
      3'd1: return m_b;
      3'd2: return m_ctrl;
      3'd3: return 32'(m_rel);
      3'd4: return 32'(m_obs);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_req(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R4";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = DIV; m_cnt = 0; m_obs = 0; m_rel = 0; m_irq = 0;
      m_a = '0; m_b = '0; m_ctrl = '0;
    end else begin
      bit tk, go;
      tk = (m_pre == 0);
      go = tk && m_ctrl[EN];
      m_irq = go && (m_cnt == 0);
      if (go) begin
        if (m_cnt == 0) begin
          m_cnt = m_rel; m_obs = m_rel;
        end else m_cnt = m_cnt - 1;
      end
      m_pre = tk ? DIV : m_pre - 1;
      if (wr_en) case (addr)
        3'd0: m_a = wdata;
        3'd1: m_b = wdata;
        3'd2: m_ctrl = wdata;
        3'd3: m_rel = int'(wdata[15:0]);
        default: ;
      endcase
    end
    #1;
    chk(irq == m_irq, "R5 irq", irq, m_irq);
    chk(rdata == exp_rd(addr), rd_req(addr), rdata, exp_rd(addr));
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic spin(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); addr = 3'(i);
      @(posedge clk); #1 if (irq) pulses++;
    end
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(posedge clk); #1 n++; end while (!irq && n < 2000);
  endtask

  initial begin
    logic [31:0] v;
    int p, n;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a); #1;
      chk(rdata == 0, "R1 reset read", rdata, 0);
    end
    chk(irq == 0, "R1 reset irq", irq, 0);
    rst_n = 1'b1;

    wr(3'd0, 32'hA5A5_1234);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_00F3);
    rd(3'd0, v); chk(v == 32'hA5A5_1234, "R7 cfg A", v, 32'hA5A5_1234);
    rd(3'd1, v); chk(v == 32'hFFFF_FFFF, "R7 cfg B", v, 32'hFFFF_FFFF);
    rd(3'd2, v); chk(v == 32'h0000_00F3, "R7 ctrl", v, 32'h0000_00F3);
    wr(3'd3, 32'h0001_2345);
    rd(3'd3, v); chk(v == 32'h2345, "R8 reload width", v, 32'h2345);

    wr(3'd4, 32'h0000_BEEF);
    wr(3'd5, 32'h1111_1111);
    wr(3'd7, 32'h2222_2222);
    rd(3'd4, v); chk(v == 0, "R9 obs write ignored", v, 0);
    rd(3'd5, v); chk(v == 0, "R9 unmapped read", v, 0);
    rd(3'd0, v); chk(v == 32'hA5A5_1234, "R9 unmapped write no alias", v, 32'hA5A5_1234);

    wr(3'd3, 32'd3);
    spin(40, p); chk(p == 0, "R3 disabled no irq", p, 0);

    wr(3'd2, 32'h0010_0000);
    wait_irq(n); chk(n <= DIV + 3, "R2 first underflow from zero", n, DIV + 3);
    rd(3'd4, v); chk(v == 3, "R4 obs after underflow", v, 3);
    wait_irq(n); chk(n == 4 * (DIV + 1), "R6 period N=3", n, 4 * (DIV + 1));
    @(posedge clk); #1 chk(irq == 0, "R5 pulse one cycle", irq, 0);

    wr(3'd3, 32'd5);
    rd(3'd4, v); chk(v == 3, "R4 obs waits for underflow", v, 3);
    wait_irq(n);
    wait_irq(n); chk(n == 6 * (DIV + 1), "R6 period N=5", n, 6 * (DIV + 1));
    rd(3'd4, v); chk(v == 5, "R4 obs follows new reload", v, 5);

    spin(3, p);
    wr(3'd2, 32'h0000_0000);
    spin(30, p); chk(p == 0, "R3 hold mid count", p, 0);
    wr(3'd2, 32'h0010_0000);
    spin(30, p); chk(p >= 2, "R2 resume counting", p, 2);

    wr(3'd3, 32'd0);
    wait_irq(n);
    wait_irq(n); chk(n == DIV + 1, "R6 period N=0", n, DIV + 1);
    wr(3'd4, 32'h0000_7777);
    rd(3'd4, v); chk(v == 0, "R9 obs write ignored while running", v, 0);
    spin(20, p);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog (all R) actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule